// File: doc/BRIEF.md
# DDR3 Read-Latency Window Tracker

This block sits on the controller side of a DDR3 command bus and follows the commands sent to the device. It reads every mode-register write to learn the CAS latency, additive latency, CAS write latency and whether the device DLL is switched off. For each READ it works out the clock in which the burst's data arrives. It then drives a data-valid strobe for the four clocks of an 8-beat burst, with the index of the even beat carried in each clock.

When the DLL is off, the device delivers data one clock early. The only legal setting in that mode is CL=6 with CWL=6, and the block flags any other value. Because the strobe delay is loose in that mode, a programmable number of extra clocks can be added to the latency to line the window up with the capture logic. A small countdown queue tracks overlapping reads. A sticky error catches a latency change while reads are in flight, and it also catches a READ that finds the queue full.

Top module: `ddr3_rd_window`

## Requirements
- R1: Commands are sampled on each rising edge. MODE REGISTER SET is cs_n=0, ras_n=0, cas_n=0, we_n=0. READ is cs_n=0, ras_n=1, cas_n=0, we_n=1. Every other pattern, and any cycle with cs_n=1, starts no read window.
- R2: A mode-register write with ba=1 loads dll_off from addr[0], where 1 means the DLL is off. Every such write updates it.
- R3: A write with ba=0 sets CL = {addr[2],addr[6:4]} + 4. A write with ba=2 sets CWL = addr[5:3] + 5.
- R4: A write with ba=1 sets the additive-latency code from addr[4:3]. Code 0 gives AL=0, code 1 gives AL=CL-1, code 2 gives AL=CL-2, and code 3 is treated as 0. AL follows the CL in force when the READ is issued.
- R5: With the DLL on, a READ sampled at edge k sets rd_valid from edge k+AL+CL+extra_dly onward.
- R6: With the DLL off, the same window starts at edge k+AL+CL-1+extra_dly.
- R7: Each window keeps rd_valid high for exactly 4 clocks. rd_beat reads 0, 2, 4, 6 in those clocks and 0 outside a window.
- R8: Up to DEPTH reads (default 4) may be outstanding. READs spaced 4 clocks apart give one unbroken valid run.
- R9: cfg_err is high whenever dll_off=1 and CL≠6 or CWL≠6.
- R10: seq_err is set by a mode-register write to ba 0, 1 or 2 while a read is queued or its window is active. It is also set by a READ that finds DEPTH reads already queued, and that READ is dropped. Once set, seq_err stays high until reset.
- R11: Reset empties the queue and restores DLL on, CL=6, AL code 0 and CWL=6. All outputs read 0.
- R12: A mode-register write with ba of 3 to 7 changes no tracked setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank address / mode-register select |
| addr | input | AW | Address bus carrying mode-register fields |
| extra_dly | input | XW | Extra clocks added to every read latency |
| rd_valid | output | 1 | Read data expected this clock |
| rd_beat | output | 3 | Even beat index of the pair in this clock |
| dll_off | output | 1 | Tracked DLL-disabled state |
| cfg_err | output | 1 | Illegal latency while the DLL is off |
| seq_err | output | 1 | Sticky sequencing or overflow error |

## Verification
A READ sampled at edge k makes rd_valid high after edge k+RL. RL is AL+CL+extra_dly, less one when the DLL is off. The window stays high through edge k+RL+3. The bench counts edges: when it drives a READ it pushes four (edge, beat) pairs, computed from its own copy of the settings, into a scoreboard queue. A monitor samples every falling edge, pops the pair due at the current edge count and flags any valid cycle that was not expected. dll_off, cfg_err and seq_err change at the edge that samples the command, so the bench checks them at the next falling edge after each command.

// File: rtl/ddr3_rd_window.sv
module ddr3_rd_window #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int XW    = 4,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic [2:0]    ba,
  input  logic [AW-1:0] addr,
  input  logic [XW-1:0] extra_dly,
  output logic          rd_valid,
  output logic [2:0]    rd_beat,
  output logic          dll_off,
  output logic          cfg_err,
  output logic          seq_err
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [4:0] cl;
  logic [3:0] cwl;
  logic [1:0] al_code;
  logic [4:0] al;
  logic [DEPTH-1:0] act;
  logic [CW-1:0] cnt [DEPTH];
  logic [DEPTH-1:0] fire;
  logic [IW-1:0] free_idx;
  logic [1:0] bcnt;
  logic [CW-1:0] rl;

  wire sel     = ~cs_n;
  wire mrs_cmd = sel & ~ras_n & ~cas_n & ~we_n;
  wire rd_cmd  = sel & ras_n & ~cas_n & we_n;
  wire mr_wr   = mrs_cmd & (ba < 3'd3);
  wire full    = &act;
  wire rd_go   = rd_cmd & ~full;
  wire busy    = (|act) | rd_valid;
  wire start   = |fire;

  always_comb begin
    case (al_code)
      2'd1:    al = cl - 5'd1;
      2'd2:    al = cl - 5'd2;
      default: al = 5'd0;
    endcase
  end

  assign rl = CW'(al) + CW'(cl) + CW'(extra_dly) - CW'(dll_off);

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!act[i]) free_idx = IW'(i);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_fire
    assign fire[g] = act[g] && (cnt[g] == CW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cl      <= 5'd6;
      cwl     <= 4'd6;
      al_code <= 2'd0;
      dll_off <= 1'b0;
      seq_err <= 1'b0;
    end else begin
      if (mrs_cmd) begin
        case (ba)
          3'd0: cl <= {1'b0, addr[2], addr[6:4]} + 5'd4;
          3'd1: begin
            dll_off <= addr[0];
            al_code <= addr[4:3];
          end
          3'd2: cwl <= {1'b0, addr[5:3]} + 4'd5;
          default: ;
        endcase
      end
      if ((mr_wr && busy) || (rd_cmd && full)) seq_err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= '0;
      for (int i = 0; i < DEPTH; i++) cnt[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (fire[i]) act[i] <= 1'b0;
        else if (act[i]) cnt[i] <= cnt[i] - CW'(1);
        if (rd_go && free_idx == IW'(i)) begin
          act[i] <= 1'b1;
          cnt[i] <= rl;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      bcnt     <= 2'd0;
    end else if (start) begin
      rd_valid <= 1'b1;
      bcnt     <= 2'd0;
    end else if (rd_valid) begin
      rd_valid <= (bcnt != 2'd3);
      bcnt     <= bcnt + 2'd1;
    end else begin
      bcnt <= 2'd0;
    end
  end

  assign rd_beat = rd_valid ? {bcnt, 1'b0} : 3'd0;
  assign cfg_err = dll_off && ((cl != 5'd6) || (cwl != 4'd6));

  assert_window_opens_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> rd_beat == 3'd0);
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);
  assert_overflow_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && full) |=> seq_err);
  assert_mr1_loads_dll_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_cmd && ba == 3'd1) |=> dll_off == $past(addr[0]));
  assert_cfg_err_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(mrs_cmd));
  assert_beat_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_beat != 3'd6 && !start) |=> rd_valid && rd_beat == $past(rd_beat) + 3'd2);
endmodule

// File: tb/ddr3_rd_window_test.sv
module ddr3_rd_window_test;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1;
  logic [2:0] ba = 0;
  logic [15:0] addr = 0;
  logic [3:0] extra_dly = 0;
  logic rd_valid, dll_off, cfg_err, seq_err;
  logic [2:0] rd_beat;

  int cyc = 0, nchk = 0, nfail = 0;
  int exp_cyc[$];
  int exp_beat[$];
  string exp_tag[$];
  int m_cl = 6, m_al = 0, m_dll = 0, m_x = 0;

  ddr3_rd_window uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .extra_dly(extra_dly), .rd_valid(rd_valid),
    .rd_beat(rd_beat), .dll_off(dll_off), .cfg_err(cfg_err), .seq_err(seq_err));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, int got, int expv);
    nchk++;
    if (got != expv) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, got, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
        nchk++;
        if (!rd_valid || rd_beat != 3'(exp_beat[0])) begin
          nfail++;
          $display("FAIL %s: valid=%0d beat=%0d expected valid=1 beat=%0d at cycle %0d",
                   exp_tag[0], rd_valid, rd_beat, exp_beat[0], cyc);
        end
        void'(exp_cyc.pop_front()); void'(exp_beat.pop_front()); void'(exp_tag.pop_front());
      end else if (rd_valid) begin
        nchk++; nfail++;
        $display("FAIL R1/R7: unexpected valid beat=%0d expected valid=0 at cycle %0d", rd_beat, cyc);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk); cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1;
    end
  endtask

  task automatic mrs(int b, int a);
    @(negedge clk); cs_n = 0; ras_n = 0; cas_n = 0; we_n = 0; ba = 3'(b); addr = 16'(a);
    if (b == 1) begin m_dll = a & 1; m_al = (a >> 3) & 3; end
    if (b == 0) m_cl = (((a >> 2) & 1) * 8) + ((a >> 4) & 7) + 4;
    @(negedge clk); cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1;
  endtask

  function automatic int mr0_for(int c);
    return (((c - 4) & 7) << 4) | ((((c - 4) >> 3) & 1) << 2);
  endfunction

  task automatic rd(string tag, bit push);
    int al, rl;
    @(negedge clk); cs_n = 0; ras_n = 1; cas_n = 0; we_n = 1; ba = 0; addr = 0;
    al = (m_al == 1) ? m_cl - 1 : (m_al == 2) ? m_cl - 2 : 0;
    rl = al + m_cl + m_x - m_dll;
    if (push)
      for (int b = 0; b < 4; b++) begin
        exp_cyc.push_back(cyc + 1 + rl + b); exp_beat.push_back(2 * b); exp_tag.push_back(tag);
      end
    @(negedge clk); cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; idle(2);
    @(negedge clk); rst_n = 1;
    m_cl = 6; m_al = 0; m_dll = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R11 valid", rd_valid, 0); chk("R11 dll_off", dll_off, 0);
    chk("R11 cfg_err", cfg_err, 0); chk("R11 seq_err", seq_err, 0);

    rd("R5 default RL", 1); idle(20);
    m_x = 2; extra_dly = 2; rd("R5 extra delay", 1); idle(20);
    m_x = 0; extra_dly = 0;

    mrs(1, 1 << 3); rd("R4 AL=CL-1", 1); idle(30);
    mrs(1, 2 << 3); rd("R4 AL=CL-2", 1); idle(30);
    mrs(1, 3 << 3); rd("R4 reserved AL", 1); idle(20);
    mrs(1, 0);
    mrs(0, mr0_for(9)); rd("R3 CL=9", 1); idle(20);
    mrs(0, mr0_for(14)); rd("R3 CL=14 high bit", 1); idle(30);
    mrs(0, mr0_for(6));

    rd("R8 b2b 0", 1); idle(2); rd("R8 b2b 1", 1); idle(2);
    rd("R8 b2b 2", 1); idle(2); rd("R8 b2b 3", 1); idle(30);

    mrs(1, 1); @(negedge clk);
    chk("R2 dll off", dll_off, 1); chk("R9 legal off", cfg_err, 0);
    rd("R6 DLL-off RL", 1); idle(20);
    m_x = 3; extra_dly = 3; rd("R6 DLL-off extra", 1); idle(20);
    m_x = 0; extra_dly = 0;

    mrs(0, mr0_for(7)); @(negedge clk); chk("R9 CL=7 off", cfg_err, 1);
    mrs(0, mr0_for(6)); @(negedge clk); chk("R9 CL restored", cfg_err, 0);
    mrs(2, 2 << 3); @(negedge clk); chk("R9 CWL=7 off", cfg_err, 1);
    mrs(2, 1 << 3); @(negedge clk); chk("R9 CWL restored", cfg_err, 0);

    mrs(3, 0); @(negedge clk); chk("R12 ba=3 ignored", dll_off, 1);
    mrs(5, 0); @(negedge clk); chk("R12 ba=5 ignored", dll_off, 1);
    mrs(1, 0); @(negedge clk); chk("R2 dll back on", dll_off, 0);
    mrs(0, mr0_for(7)); @(negedge clk); chk("R9 DLL on any CL", cfg_err, 0);
    mrs(4, 1); @(negedge clk); chk("R12 ba=4 ignored", dll_off, 0);
    mrs(0, mr0_for(6));
    rd("R12 CL unchanged", 1); idle(20);

    @(negedge clk); cs_n = 1; ras_n = 1; cas_n = 0; we_n = 1; idle(1); idle(15);
    @(negedge clk); cs_n = 0; ras_n = 0; cas_n = 0; we_n = 1; idle(1); idle(15);
    chk("R1 non-read no window", exp_cyc.size(), 0);
    chk("R10 no error yet", seq_err, 0);

    rd("R10 pending", 1); mrs(2, 1 << 3); @(negedge clk);
    chk("R10 mrs while busy", seq_err, 1);
    idle(20); chk("R10 sticky", seq_err, 1);

    do_reset(); @(negedge clk);
    chk("R11 seq_err cleared", seq_err, 0); chk("R11 dll on", dll_off, 0);
    rd("R11 default RL after reset", 1); idle(20);

    mrs(0, mr0_for(19)); mrs(1, 1 << 3);
    rd("R8 deep 0", 1); idle(2); rd("R8 deep 1", 1); idle(2);
    rd("R8 deep 2", 1); idle(2); rd("R8 deep 3", 1); idle(2);
    chk("R10 not full yet", seq_err, 0);
    rd("R10 overflow dropped", 0); @(negedge clk);
    chk("R10 overflow flag", seq_err, 1);
    idle(70);
    chk("R8 all windows seen", exp_cyc.size(), 0);

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule